// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Pending Logic

This block holds the interrupt-pending state of a two-channel serial controller. Each channel, A and B, has three interrupt sources: external/status change, transmit complete and receive character available. Each source that is enabled and fires sets its own bit in a shared six-bit pending register. The CPU reads that register through channel A's view. Through channel B's view it reads as zero. When the master enable is on and any bit is pending, an active-low interrupt request is raised.

The CPU talks to each channel through a register-select and write-data bus. Register 0 carries commands in bits 5:3. Register 1 holds the per-channel source enables. Register 9 holds the master enable, and either channel can write it. One command clears a channel's transmit-pending bit and also disarms that channel's transmit interrupt. The interrupt stays disarmed until the CPU writes the next byte to that channel's transmit buffer. Whether the channel is disarmed is judged at the moment a transmission completes. So a disarm command issued after the byte write, but before the shifter finishes, still suppresses the interrupt.

Top module: `serial_irq_pending`

## Requirements
- R1: A synchronous active-high reset clears all pending bits, the disarm flags, the source enables and the master enable. After reset, the read value is 0 and the request output is high.
- R2: The pending register layout is fixed. Bit 0 is B ext/status, bit 1 is B transmit, bit 2 is B receive. Bit 3 is A ext/status, bit 4 is A transmit, bit 5 is A receive.
- R3: With the read-view select at 0 (channel A), the read output shows the pending register with bits 7:6 at 0. With the select at 1 (channel B), the read output is all zeros. The read output is registered and shows the state of the previous cycle.
- R4: An ext/status change pulse sets that channel's ext bit only while register 1 bit 0 is set. Writing command code 3'b010 in register 0 bits 5:3 clears the ext bit of the addressed channel only.
- R5: A transmit-complete pulse sets that channel's transmit bit only when register 1 bit 1 is set and the channel is not disarmed.
- R6: Writing command code 3'b101 in register 0 bits 5:3 clears the transmit bit of the addressed channel only. It also disarms that channel, so later transmit-complete pulses set nothing.
- R7: A transmit-buffer data write re-arms the channel. A 3'b101 command after that write and before completion disarms it again. A command in the same cycle as the data write leaves the channel disarmed.
- R8: A receive-available pulse sets that channel's receive bit only when register 1 bits 4:3 are nonzero. A receive-data read strobe clears it.
- R9: The request output goes low in the cycle after an update exactly when register 9 bit 3 is set and any pending bit is set. Register 9 can be written through either channel.
- R10: A source whose enable is clear never sets its bit. Clearing an enable does not remove a bit that is already pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 2 | Control-register write strobe per channel (index 0 = A) |
| ctl_sel | input | 2x4 | Register number per channel |
| ctl_wdat | input | 2x8 | Control write data per channel |
| dat_wr | input | 2 | Transmit-buffer data write strobe per channel |
| dat_rd | input | 2 | Receive-data read strobe per channel |
| tx_done | input | 2 | Transmit-complete pulse per channel |
| rx_avail | input | 2 | Receive-character-available pulse per channel |
| ext_chg | input | 2 | External/status change pulse per channel |
| rd_ch | input | 1 | Pending-register read view: 0 = channel A, 1 = channel B |
| pend_rd | output | 8 | Registered pending-register read value |
| irq_n | output | 1 | Registered active-low interrupt request |

## Verification
Some properties are checked by assertions on every cycle. The request output must agree with the master enable and the pending bits in both directions. The read value's top bits stay zero, and channel B's view stays zero. The channel-A transmit-reset command and the receive-read strobe take effect in the next cycle. A disarmed channel A ignores the next transmit completion when no byte is written. Other behaviour is shown only by the bench scenarios. These cover the bit placement for every enable combination on both channels and the clearing of one channel without touching the other. They also cover re-arming by a data write, a command that arrives between the write and the completion, a command in the same cycle as the write, and the master enable written through channel B.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int NCH   = 2;
  localparam int SEL_W = 4;
  localparam int DW    = 8;
  localparam int NSRC  = 3;
  localparam int PW    = NCH * NSRC;

  localparam logic [SEL_W-1:0] REG_CMD  = 4'd0;
  localparam logic [SEL_W-1:0] REG_IE   = 4'd1;
  localparam logic [SEL_W-1:0] REG_MSTR = 4'd9;

  localparam logic [2:0] CMD_CLR_EXT = 3'b010;
  localparam logic [2:0] CMD_CLR_TXP = 3'b101;

  localparam int MIE_BIT = 3;

  typedef struct packed {
    logic rx;
    logic tx;
    logic ext;
  } src_t;
endpackage

// File: rtl/sirq_chan_ctl.sv
module sirq_chan_ctl
  import sirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [SEL_W-1:0] ctl_sel,
  input  logic [DW-1:0]    ctl_wdat,
  input  logic             dat_wr,
  input  logic             dat_rd,
  input  logic             tx_done,
  input  logic             rx_avail,
  input  logic             ext_chg,
  output src_t             set_o,
  output src_t             clr_o
);
  logic       ext_ie_q, tx_ie_q;
  logic [1:0] rx_mode_q;
  logic       disarm_q, disarm_nx;
  logic       wr_cmd, wr_ie;
  logic [2:0] cmd;
  logic       unused_bits;

  assign unused_bits = ^{ctl_wdat[7:6], ctl_wdat[2]};

  assign wr_cmd = ctl_wr && (ctl_sel == REG_CMD);
  assign wr_ie  = ctl_wr && (ctl_sel == REG_IE);
  assign cmd    = ctl_wdat[5:3];

  always_comb begin
    disarm_nx = disarm_q;
    if (dat_wr)
      disarm_nx = 1'b0;
    if (wr_cmd && cmd == CMD_CLR_TXP)
      disarm_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_ie_q  <= 1'b0;
      tx_ie_q   <= 1'b0;
      rx_mode_q <= 2'b00;
      disarm_q  <= 1'b0;
    end else begin
      disarm_q <= disarm_nx;
      if (wr_ie) begin
        ext_ie_q  <= ctl_wdat[0];
        tx_ie_q   <= ctl_wdat[1];
        rx_mode_q <= ctl_wdat[4:3];
      end
    end
  end

  always_comb begin
    set_o.ext = ext_chg && ext_ie_q;
    set_o.tx  = tx_done && tx_ie_q && !disarm_nx;
    set_o.rx  = rx_avail && (rx_mode_q != 2'b00);
    clr_o.ext = wr_cmd && (cmd == CMD_CLR_EXT);
    clr_o.tx  = wr_cmd && (cmd == CMD_CLR_TXP);
    clr_o.rx  = dat_rd;
  end
endmodule

// File: rtl/sirq_pend_reg.sv
module sirq_pend_reg
  import sirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  src_t [NCH-1:0]  set_i,
  input  src_t [NCH-1:0]  clr_i,
  output logic [PW-1:0]   pend_q,
  output logic [PW-1:0]   pend_nx
);
  logic [PW-1:0] set_v, clr_v;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_map
    localparam int BASE = (NCH - 1 - ch) * NSRC;
    assign set_v[BASE +: NSRC] = set_i[ch];
    assign clr_v[BASE +: NSRC] = clr_i[ch];
  end

  assign pend_nx = (pend_q & ~clr_v) | set_v;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_nx;
  end
endmodule

// File: rtl/sirq_out.sv
module sirq_out
  import sirq_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NCH-1:0]            ctl_wr,
  input  logic [NCH-1:0][SEL_W-1:0] ctl_sel,
  input  logic [NCH-1:0][DW-1:0]    ctl_wdat,
  input  logic [PW-1:0]             pend_q,
  input  logic [PW-1:0]             pend_nx,
  input  logic                      rd_ch,
  output logic                      mie_q,
  output logic                      irq_n,
  output logic [DW-1:0]             pend_rd
);
  logic mie_nx;

  always_comb begin
    mie_nx = mie_q;
    for (int ch = NCH - 1; ch >= 0; ch--) begin
      if (ctl_wr[ch] && ctl_sel[ch] == REG_MSTR)
        mie_nx = ctl_wdat[ch][MIE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mie_q   <= 1'b0;
      irq_n   <= 1'b1;
      pend_rd <= '0;
    end else begin
      mie_q   <= mie_nx;
      irq_n   <= !(mie_nx && (pend_nx != '0));
      pend_rd <= rd_ch ? '0 : DW'(pend_q);
    end
  end
endmodule

// File: rtl/serial_irq_pending.sv
module serial_irq_pending
  import sirq_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NCH-1:0]            ctl_wr,
  input  logic [NCH-1:0][SEL_W-1:0] ctl_sel,
  input  logic [NCH-1:0][DW-1:0]    ctl_wdat,
  input  logic [NCH-1:0]            dat_wr,
  input  logic [NCH-1:0]            dat_rd,
  input  logic [NCH-1:0]            tx_done,
  input  logic [NCH-1:0]            rx_avail,
  input  logic [NCH-1:0]            ext_chg,
  input  logic                      rd_ch,
  output logic [DW-1:0]             pend_rd,
  output logic                      irq_n
);
  src_t [NCH-1:0] src_set, src_clr;
  logic [PW-1:0]  pend_q, pend_nx;
  logic           mie_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    sirq_chan_ctl u_ctl (
      .clk      (clk),
      .rst      (rst),
      .ctl_wr   (ctl_wr[ch]),
      .ctl_sel  (ctl_sel[ch]),
      .ctl_wdat (ctl_wdat[ch]),
      .dat_wr   (dat_wr[ch]),
      .dat_rd   (dat_rd[ch]),
      .tx_done  (tx_done[ch]),
      .rx_avail (rx_avail[ch]),
      .ext_chg  (ext_chg[ch]),
      .set_o    (src_set[ch]),
      .clr_o    (src_clr[ch])
    );
  end

  sirq_pend_reg u_pend (
    .clk     (clk),
    .rst     (rst),
    .set_i   (src_set),
    .clr_i   (src_clr),
    .pend_q  (pend_q),
    .pend_nx (pend_nx)
  );

  sirq_out u_out (
    .clk      (clk),
    .rst      (rst),
    .ctl_wr   (ctl_wr),
    .ctl_sel  (ctl_sel),
    .ctl_wdat (ctl_wdat),
    .pend_q   (pend_q),
    .pend_nx  (pend_nx),
    .rd_ch    (rd_ch),
    .mie_q    (mie_q),
    .irq_n    (irq_n),
    .pend_rd  (pend_rd)
  );
endmodule

// File: rtl/serial_irq_pending_chk.sv
module serial_irq_pending_chk
  import sirq_pkg::*;
(
  input logic                      clk,
  input logic                      rst,
  input logic [NCH-1:0]            ctl_wr,
  input logic [NCH-1:0][SEL_W-1:0] ctl_sel,
  input logic [NCH-1:0][DW-1:0]    ctl_wdat,
  input logic [NCH-1:0]            dat_wr,
  input logic [NCH-1:0]            dat_rd,
  input logic [NCH-1:0]            rx_avail,
  input logic                      rd_ch,
  input logic [DW-1:0]             pend_rd,
  input logic                      irq_n,
  input logic [PW-1:0]             pend_q,
  input logic                      mie_q
);
  logic cmd_txp_a;
  assign cmd_txp_a = ctl_wr[0] && ctl_sel[0] == REG_CMD && ctl_wdat[0][5:3] == CMD_CLR_TXP;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pend_q == '0 && irq_n && pend_rd == '0));

  a_r3_top_bits_zero: assert property (@(posedge clk) disable iff (rst)
    pend_rd[DW-1:PW] == '0);

  a_r3_chan_b_view_zero: assert property (@(posedge clk) disable iff (rst)
    rd_ch |=> pend_rd == '0);

  a_r6_cmd_clears_tx_a: assert property (@(posedge clk) disable iff (rst)
    cmd_txp_a |=> !pend_q[4]);

  a_r7_disarm_holds_a: assert property (@(posedge clk) disable iff (rst)
    cmd_txp_a ##1 (!dat_wr[0] && !ctl_wr[0]) |=> !pend_q[4]);

  a_r8_read_clears_rx_a: assert property (@(posedge clk) disable iff (rst)
    (dat_rd[0] && !rx_avail[0]) |=> !pend_q[5]);

  a_r9_irq_needs_cause: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> (mie_q && pend_q != '0));

  a_r9_cause_gives_irq: assert property (@(posedge clk) disable iff (rst)
    (mie_q && pend_q != '0) |-> !irq_n);
endmodule

bind serial_irq_pending serial_irq_pending_chk u_chk (.*);

// File: tb/tb_serial_irq_pending.sv
module tb_serial_irq_pending;
  localparam int CLK_P = 10;

  logic            clk = 1'b0;
  logic            rst;
  logic [1:0]      ctl_wr;
  logic [1:0][3:0] ctl_sel;
  logic [1:0][7:0] ctl_wdat;
  logic [1:0]      dat_wr, dat_rd, tx_done, rx_avail, ext_chg;
  logic            rd_ch;
  logic [7:0]      pend_rd;
  logic            irq_n;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  serial_irq_pending dut (.*);

  task automatic idle();
    ctl_wr = '0; ctl_sel = '0; ctl_wdat = '0;
    dat_wr = '0; dat_rd = '0; tx_done = '0; rx_avail = '0; ext_chg = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic set_ctl(int ch, logic [3:0] sel, logic [7:0] d);
    ctl_wr[ch] = 1'b1; ctl_sel[ch] = sel; ctl_wdat[ch] = d;
  endtask

  task automatic wreg(int ch, logic [3:0] sel, logic [7:0] d);
    set_ctl(ch, sel, d);
    tick();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    rst = 1'b0;
  endtask

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_read(string req, logic [5:0] exp);
    rd_ch = 1'b0;
    @(negedge clk);
    chk(req, {1'b0, pend_rd}, {3'b000, exp});
  endtask

  task automatic chk_read_b(string req);
    rd_ch = 1'b1;
    @(negedge clk);
    chk(req, {1'b0, pend_rd}, 9'd0);
    rd_ch = 1'b0;
  endtask

  function automatic logic [5:0] place(int ch, logic [2:0] bits);
    return (ch == 0) ? {bits, 3'b000} : {3'b000, bits};
  endfunction

  initial begin
    #(CLK_P * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    rd_ch = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    chk("R1 reset read", {1'b0, pend_rd}, 9'd0);
    chk("R1 reset irq_n", {8'd0, irq_n}, 9'd1);
    ext_chg = 2'b11; tx_done = 2'b11; rx_avail = 2'b11;
    tick();
    chk_read("R1 R10 enables cleared by reset", 6'd0);

    // R2 R5 R8 R10 R9 sweep of every enable combination per channel
    for (int ch = 0; ch < 2; ch++) begin
      for (int cfg = 0; cfg < 16; cfg++) begin
        logic [2:0] bits;
        logic [5:0] exp;
        do_reset();
        wreg(ch, 4'd1, {3'b000, cfg[3:2], 1'b0, cfg[1:0]});
        ext_chg[ch] = 1'b1; tx_done[ch] = 1'b1; rx_avail[ch] = 1'b1;
        tick();
        bits = {cfg[3:2] != 2'b00, cfg[1], cfg[0]};
        exp  = place(ch, bits);
        chk_read($sformatf("R2 R5 R8 R10 ch%0d cfg%0d", ch, cfg), exp);
        chk_read_b("R3 channel B view");
        chk("R9 irq off without master", {8'd0, irq_n}, 9'd1);
        wreg(1 - ch, 4'd9, 8'h08);
        chk("R9 irq with master", {8'd0, irq_n}, {8'd0, exp == 6'd0});
      end
    end

    // R4 ext set and clear per channel
    do_reset();
    wreg(0, 4'd1, 8'h01); wreg(1, 4'd1, 8'h01);
    ext_chg = 2'b11; tick();
    chk_read("R4 both ext set", 6'b001001);
    wreg(1, 4'd0, {2'b00, 3'b010, 3'b000});
    chk_read("R4 clear ext B only", 6'b001000);
    wreg(0, 4'd1, 8'h00);
    chk_read("R10 disable keeps pending", 6'b001000);
    wreg(0, 4'd0, {2'b00, 3'b010, 3'b000});
    chk_read("R4 clear ext A", 6'b000000);

    // R6 R7 transmit disarm and re-arm
    do_reset();
    wreg(0, 4'd1, 8'h02); wreg(1, 4'd1, 8'h02);
    tx_done = 2'b11; tick();
    chk_read("R5 both tx set", 6'b010010);
    wreg(0, 4'd0, {2'b00, 3'b101, 3'b000});
    chk_read("R6 clear tx A only", 6'b000010);
    tx_done[0] = 1'b1; tick();
    chk_read("R6 disarmed A ignores completion", 6'b000010);
    tx_done[1] = 1'b1; wreg(1, 4'd0, {2'b00, 3'b101, 3'b000});
    chk_read("R6 clear tx B with same-cycle completion", 6'b000000);
    dat_wr[0] = 1'b1; tick();
    tx_done[0] = 1'b1; tick();
    chk_read("R7 data write re-arms", 6'b010000);
    dat_wr[0] = 1'b1; tick();
    wreg(0, 4'd0, {2'b00, 3'b101, 3'b000});
    tx_done[0] = 1'b1; tick();
    chk_read("R7 command after write disarms", 6'b000000);
    dat_wr[0] = 1'b1; set_ctl(0, 4'd0, {2'b00, 3'b101, 3'b000}); tick();
    tx_done[0] = 1'b1; tick();
    chk_read("R7 same-cycle command wins", 6'b000000);
    dat_wr[0] = 1'b1; tick();
    tx_done[0] = 1'b1; tick();
    chk_read("R7 re-armed again", 6'b010000);

    // R8 receive clear by data read
    do_reset();
    wreg(0, 4'd1, 8'h10); wreg(1, 4'd1, 8'h08);
    rx_avail = 2'b11; tick();
    chk_read("R8 both rx set", 6'b100100);
    dat_rd[0] = 1'b1; tick();
    chk_read("R8 read clears A only", 6'b000100);
    wreg(0, 4'd9, 8'h08);
    chk("R9 irq from B rx", {8'd0, irq_n}, 9'd0);
    dat_rd[1] = 1'b1; tick();
    chk("R9 irq released", {8'd0, irq_n}, 9'd1);
    chk_read("R8 read clears B", 6'b000000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule